// File: doc/BRIEF.md
# CPU-to-ISA I/O Address Bridge

This block sits between a processor's memory bus and a legacy ISA-style port bus. A processor access that lands in an 8 MB I/O window is turned into a single ISA port cycle, with the 16-bit port number derived from the CPU address under one of two layouts. The flat layout uses the low 16 address bits directly. The sparse layout gives every group of 32 ports a 4 KB page of its own, so that software can protect port groups with page-granular memory mapping.

When the processor runs big-endian, halfword and word data are byte-swapped on the way out and on the way back, so that little-endian ISA peripherals present their registers in the expected order. A fixed four-byte location outside the window serves interrupt acknowledge. A read of its first byte fetches the vector from an external interrupt controller. Everything else in that location reads as zero and ignores writes.

The CPU holds `cpu_rd` or `cpu_wr` until it sees a one-cycle `cpu_ready` pulse. The mode controls and the size are captured when the access is launched. Only one access is outstanding at any time.

Top module: `isa_io_bridge`

## Requirements
- R1: After reset, `isa_rd`, `isa_wr`, `iack_req` and `cpu_ready` are low and `cpu_rdata` is zero.
- R2: An access with `cpu_addr` in 0x80000000..0x807FFFFF starts exactly one ISA cycle, and the direction follows the CPU strobe. The ISA strobe stays high until `isa_ack` is sampled. `cpu_ready` then pulses for exactly one cycle, in the cycle after the acknowledge.
- R3: With `map_sparse` = 0, `isa_addr` equals `cpu_addr[15:0]`.
- R4: With `map_sparse` = 1, `isa_addr` equals `(cpu_addr & 0x1F) | ((cpu_addr & 0x7FFF000) >> 7)`, which is `{cpu_addr[22:12], cpu_addr[4:0]}`. Address bits 11:5 have no effect on the port number.
- R5: The size code is copied to `isa_size` unchanged: 0 means byte, 1 means halfword, 2 means word.
- R6: For writes with `cpu_big_endian` = 1, a halfword exchanges byte lanes 0 and 1 and leaves lanes 2 and 3 as they are, and a word reverses all four lanes. Byte accesses are never swapped. With `cpu_big_endian` = 0, no access is swapped.
- R7: Read data returned from the ISA side is swapped by the same rule as R6, using the size and endian mode of the access.
- R8: A read at 0xBFFFFFF0 raises `iack_req` and holds it until `iack_valid` is sampled. It starts no ISA cycle. It returns the vector zero-extended to 32 bits and then swapped by the rule of R6.
- R9: Reads at 0xBFFFFFF1 to 0xBFFFFFF3 return zero and raise neither `iack_req` nor an ISA strobe.
- R10: Writes anywhere in 0xBFFFFFF0 to 0xBFFFFFF3 raise no strobe and complete with `cpu_ready`.
- R11: Accesses outside both regions raise no strobe and complete with `cpu_ready`, returning zero.
- R12: The endian mode, layout, size and write data are captured when the access starts. Changes to `cpu_big_endian` or `map_sparse` while the access is outstanding alter neither the ISA address, nor the ISA data, nor the returned data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | CPU read request, held until ready |
| cpu_wr | input | 1 | CPU write request, held until ready |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | CPU write data |
| cpu_big_endian | input | 1 | 1 when the CPU runs big-endian |
| map_sparse | input | 1 | 0 for the flat port layout, 1 for the sparse page layout |
| cpu_rdata | output | 32 | Read data, valid during cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| isa_addr | output | 16 | ISA port number |
| isa_size | output | 2 | ISA access size |
| isa_wdata | output | 32 | ISA write data, lane-ordered |
| isa_rd | output | 1 | ISA read strobe |
| isa_wr | output | 1 | ISA write strobe |
| isa_rdata | input | 32 | ISA read data |
| isa_ack | input | 1 | ISA cycle acknowledge |
| iack_req | output | 1 | Vector fetch request to the interrupt controller |
| iack_vector | input | 8 | Interrupt vector |
| iack_valid | input | 1 | Vector valid |

## Verification
The two functions that can meet in one cycle are the completion of an outstanding ISA read and a change of the endian and layout controls. The bench raises `isa_ack` and inverts `cpu_big_endian` and `map_sparse` in the same cycle. It then expects the returned word to be swapped under the endian mode in force at launch, and the port number to match the launch-time layout. Acknowledges held back for several cycles confirm that the strobe and its address stay put while the controls move.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ISA  = 2'd1,
      ST_IACK = 2'd2,
      ST_DONE = 2'd3
   } seq_state_e;

endpackage

// File: rtl/isa_lane_swap.sv
module isa_lane_swap #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        size,
   input  logic              big_endian,
   output logic [DATA_W-1:0] dout
);
   import isa_bridge_pkg::*;

   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] rev_word;
   logic [DATA_W-1:0] rev_half;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign rev_word[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
         if (i < 2) begin : g_low
            assign rev_half[i*8 +: 8] = din[(1-i)*8 +: 8];
         end else begin : g_high
            assign rev_half[i*8 +: 8] = din[i*8 +: 8];
         end
      end
   endgenerate

   always_comb begin
      dout = din;
      if (big_endian) begin
         case (xfer_size_e'(size))
            SZ_HALF: dout = rev_half;
            SZ_WORD: dout = rev_word;
            default: dout = din;
         endcase
      end
   end

endmodule

// File: rtl/isa_addr_map.sv
module isa_addr_map #(
   parameter int              ADDR_W    = 32,
   parameter int              PORT_W    = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
   parameter int              WIN_LOG2  = 23,
   parameter int              PAGE_LOG2 = 12,
   parameter int              LO_BITS   = 5,
   parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0
) (
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              map_sparse,
   output logic              hit_io,
   output logic              hit_iack,
   output logic [PORT_W-1:0] port_addr
);
   localparam int HI_W = PORT_W - LO_BITS;

   logic [PORT_W-1:0] flat_port;
   logic [PORT_W-1:0] sparse_port;

   assign hit_io      = (cpu_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
   assign hit_iack    = (cpu_addr == IACK_ADDR);
   assign flat_port   = cpu_addr[PORT_W-1:0];
   assign sparse_port = {cpu_addr[PAGE_LOG2+HI_W-1:PAGE_LOG2], cpu_addr[LO_BITS-1:0]};
   assign port_addr   = map_sparse ? sparse_port : flat_port;

endmodule

// File: rtl/isa_bridge_seq.sv
module isa_bridge_seq #(
   parameter int DATA_W = 32,
   parameter int PORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              hit_io,
   input  logic              hit_iack,
   input  logic [PORT_W-1:0] port_addr,
   input  logic [1:0]        cpu_size,
   input  logic              cpu_big_endian,
   input  logic [DATA_W-1:0] wdata_sw,
   input  logic              isa_ack,
   input  logic              iack_valid,
   input  logic [DATA_W-1:0] rdata_sw,
   output logic [PORT_W-1:0] isa_addr,
   output logic [1:0]        isa_size,
   output logic [DATA_W-1:0] isa_wdata,
   output logic              isa_rd,
   output logic              isa_wr,
   output logic              iack_req,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [1:0]        lat_size,
   output logic              lat_be,
   output logic              sel_vec
);
   import isa_bridge_pkg::*;

   seq_state_e state;
   logic       is_rd;

   assign is_rd = cpu_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         isa_addr  <= '0;
         isa_size  <= '0;
         isa_wdata <= '0;
         isa_rd    <= 1'b0;
         isa_wr    <= 1'b0;
         iack_req  <= 1'b0;
         cpu_ready <= 1'b0;
         cpu_rdata <= '0;
         lat_size  <= '0;
         lat_be    <= 1'b0;
         sel_vec   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cpu_rd || cpu_wr) begin
                  lat_size <= cpu_size;
                  lat_be   <= cpu_big_endian;
                  if (hit_io) begin
                     isa_addr  <= port_addr;
                     isa_size  <= cpu_size;
                     isa_wdata <= is_rd ? '0 : wdata_sw;
                     isa_rd    <= is_rd;
                     isa_wr    <= !is_rd;
                     sel_vec   <= 1'b0;
                     state     <= ST_ISA;
                  end else if (hit_iack && is_rd) begin
                     iack_req <= 1'b1;
                     sel_vec  <= 1'b1;
                     state    <= ST_IACK;
                  end else begin
                     cpu_ready <= 1'b1;
                     cpu_rdata <= '0;
                     state     <= ST_DONE;
                  end
               end
            end
            ST_ISA: begin
               if (isa_ack) begin
                  isa_rd    <= 1'b0;
                  isa_wr    <= 1'b0;
                  cpu_ready <= 1'b1;
                  cpu_rdata <= isa_rd ? rdata_sw : '0;
                  state     <= ST_DONE;
               end
            end
            ST_IACK: begin
               if (iack_valid) begin
                  iack_req  <= 1'b0;
                  cpu_ready <= 1'b1;
                  cpu_rdata <= rdata_sw;
                  state     <= ST_DONE;
               end
            end
            default: begin
               cpu_ready <= 1'b0;
               cpu_rdata <= '0;
               state     <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                PORT_W    = 16,
   parameter int                VEC_W     = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
   parameter int                WIN_LOG2  = 23,
   parameter int                PAGE_LOG2 = 12,
   parameter int                LO_BITS   = 5,
   parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_big_endian,
   input  logic              map_sparse,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic [PORT_W-1:0] isa_addr,
   output logic [1:0]        isa_size,
   output logic [DATA_W-1:0] isa_wdata,
   output logic              isa_rd,
   output logic              isa_wr,
   input  logic [DATA_W-1:0] isa_rdata,
   input  logic              isa_ack,
   output logic              iack_req,
   input  logic [VEC_W-1:0]  iack_vector,
   input  logic              iack_valid
);
   localparam int HI_W = PORT_W - LO_BITS;

   initial begin : elab_checks
      assert (DATA_W >= 32 && DATA_W % 8 == 0)
         else $fatal(1, "DATA_W must be a multiple of 8 and at least 32");
      assert (VEC_W > 0 && VEC_W < DATA_W)
         else $fatal(1, "VEC_W must be narrower than DATA_W");
      assert (LO_BITS > 0 && LO_BITS < PORT_W && LO_BITS <= PAGE_LOG2)
         else $fatal(1, "LO_BITS out of range");
      assert (PAGE_LOG2 + HI_W <= WIN_LOG2 && PORT_W <= WIN_LOG2)
         else $fatal(1, "window too small for the port layouts");
      assert (WIN_LOG2 < ADDR_W)
         else $fatal(1, "window larger than address space");
   end

   logic              hit_io;
   logic              hit_iack;
   logic [PORT_W-1:0] port_addr;
   logic [DATA_W-1:0] wdata_sw;
   logic [DATA_W-1:0] rd_src;
   logic [DATA_W-1:0] rdata_sw;
   logic [1:0]        lat_size;
   logic              lat_be;
   logic              sel_vec;

   isa_addr_map #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
      .PAGE_LOG2(PAGE_LOG2), .LO_BITS(LO_BITS), .IACK_ADDR(IACK_ADDR)
   ) u_map (
      .cpu_addr  (cpu_addr),
      .map_sparse(map_sparse),
      .hit_io    (hit_io),
      .hit_iack  (hit_iack),
      .port_addr (port_addr)
   );

   isa_lane_swap #(.DATA_W(DATA_W)) u_wswap (
      .din       (cpu_wdata),
      .size      (cpu_size),
      .big_endian(cpu_big_endian),
      .dout      (wdata_sw)
   );

   assign rd_src = sel_vec ? {{(DATA_W-VEC_W){1'b0}}, iack_vector} : isa_rdata;

   isa_lane_swap #(.DATA_W(DATA_W)) u_rswap (
      .din       (rd_src),
      .size      (lat_size),
      .big_endian(lat_be),
      .dout      (rdata_sw)
   );

   isa_bridge_seq #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_rd        (cpu_rd),
      .cpu_wr        (cpu_wr),
      .hit_io        (hit_io),
      .hit_iack      (hit_iack),
      .port_addr     (port_addr),
      .cpu_size      (cpu_size),
      .cpu_big_endian(cpu_big_endian),
      .wdata_sw      (wdata_sw),
      .isa_ack       (isa_ack),
      .iack_valid    (iack_valid),
      .rdata_sw      (rdata_sw),
      .isa_addr      (isa_addr),
      .isa_size      (isa_size),
      .isa_wdata     (isa_wdata),
      .isa_rd        (isa_rd),
      .isa_wr        (isa_wr),
      .iack_req      (iack_req),
      .cpu_ready     (cpu_ready),
      .cpu_rdata     (cpu_rdata),
      .lat_size      (lat_size),
      .lat_be        (lat_be),
      .sel_vec       (sel_vec)
   );

endmodule

// File: rtl/isa_io_bridge_chk.sv
module isa_io_bridge_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int PORT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [1:0]        cpu_size,
   input logic              map_sparse,
   input logic              cpu_ready,
   input logic [PORT_W-1:0] isa_addr,
   input logic [1:0]        isa_size,
   input logic [DATA_W-1:0] isa_wdata,
   input logic              isa_rd,
   input logic              isa_wr,
   input logic              isa_ack,
   input logic              iack_req,
   input logic              iack_valid
);
   logic strobe;
   assign strobe = isa_rd || isa_wr;

   AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && !isa_ack |=> strobe); // R2
   AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && isa_ack |=> cpu_ready && !strobe); // R2
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R2
   AST_FLAT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) && !$past(map_sparse) |-> isa_addr == $past(cpu_addr[PORT_W-1:0])); // R3
   AST_SIZE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> isa_size == $past(cpu_size)); // R5
   AST_IACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      iack_req && !iack_valid |=> iack_req); // R8
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe && iack_req) && !(isa_rd && isa_wr)); // R9
   AST_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && !isa_ack |=> $stable(isa_addr) && $stable(isa_wdata) && $stable(isa_size)); // R12

endmodule

bind isa_io_bridge isa_io_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_size  (cpu_size),
   .map_sparse(map_sparse),
   .cpu_ready (cpu_ready),
   .isa_addr  (isa_addr),
   .isa_size  (isa_size),
   .isa_wdata (isa_wdata),
   .isa_rd    (isa_rd),
   .isa_wr    (isa_wr),
   .isa_ack   (isa_ack),
   .iack_req  (iack_req),
   .iack_valid(iack_valid)
);

// File: tb/isa_io_bridge_bench.sv
`timescale 1ns/1ps
module isa_io_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_big_endian = 1'b0;
   logic        map_sparse = 1'b0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready;
   logic [15:0] isa_addr;
   logic [1:0]  isa_size;
   logic [31:0] isa_wdata;
   logic        isa_rd;
   logic        isa_wr;
   logic [31:0] isa_rdata = '0;
   logic        isa_ack = 1'b0;
   logic        iack_req;
   logic [7:0]  iack_vector = '0;
   logic        iack_valid = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   isa_io_bridge u_isa_io_bridge (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_big_endian(cpu_big_endian), .map_sparse(map_sparse),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .isa_addr(isa_addr),
      .isa_size(isa_size), .isa_wdata(isa_wdata), .isa_rd(isa_rd), .isa_wr(isa_wr),
      .isa_rdata(isa_rdata), .isa_ack(isa_ack), .iack_req(iack_req),
      .iack_vector(iack_vector), .iack_valid(iack_valid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // One CPU access with a responding ISA device and interrupt controller.
   task automatic xfer(input bit rd, input logic [31:0] addr, input logic [1:0] size,
                       input logic [31:0] wdata, input bit be, input bit sp,
                       input int ack_delay, input logic [31:0] dev_data,
                       input logic [7:0] vec, input bit exp_isa, input logic [15:0] exp_port,
                       input logic [31:0] exp_wdata, input bit exp_iack,
                       input logic [31:0] exp_rdata, input bit flip, input string req);
      bit seen_isa = 0;
      bit seen_iack = 0;
      bit got = 0;
      bit acked = 0;
      int waited = 0;
      @(negedge clk);
      cpu_addr = addr; cpu_size = size; cpu_wdata = wdata;
      cpu_big_endian = be; map_sparse = sp;
      cpu_rd = rd; cpu_wr = !rd;
      for (int n = 0; n < 40 && !got; n++) begin
         @(negedge clk);
         isa_ack = 1'b0; iack_valid = 1'b0;
         if (cpu_ready) begin
            got = 1;
            check(cpu_rdata == exp_rdata, {req, " rdata"}, cpu_rdata, exp_rdata);
         end else begin
            if (seen_isa && !acked)
               check(isa_rd || isa_wr, "R2 strobe held", {30'd0, isa_rd, isa_wr}, 32'd1);
            if (isa_rd || isa_wr) begin
               if (!seen_isa) begin
                  check(isa_addr == exp_port, {req, " port"}, {16'd0, isa_addr}, {16'd0, exp_port});
                  check(isa_size == size, "R5 size", {30'd0, isa_size}, {30'd0, size});
                  check(isa_rd == rd && isa_wr == !rd, "R2 direction",
                        {30'd0, isa_rd, isa_wr}, {30'd0, rd, !rd});
                  if (!rd) check(isa_wdata == exp_wdata, {req, " wdata"}, isa_wdata, exp_wdata);
               end
               seen_isa = 1;
               if (waited == ack_delay) begin
                  isa_ack = 1'b1; isa_rdata = dev_data; acked = 1;
                  if (flip) begin
                     cpu_big_endian = !cpu_big_endian; map_sparse = !map_sparse;
                  end
               end else waited++;
            end
            if (iack_req) begin
               seen_iack = 1;
               if (waited == ack_delay) begin
                  iack_valid = 1'b1; iack_vector = vec;
               end else waited++;
            end
         end
      end
      check(got, {req, " ready"}, {31'd0, got}, 32'd1);
      check(seen_isa == exp_isa, {req, " isa cycle"}, {31'd0, seen_isa}, {31'd0, exp_isa});
      check(seen_iack == exp_iack, {req, " iack req"}, {31'd0, seen_iack}, {31'd0, exp_iack});
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      @(negedge clk);
      check(!cpu_ready, "R2 ready single pulse", {31'd0, cpu_ready}, 32'd0);
   endtask

   task automatic t_reset();
      check(!isa_rd && !isa_wr && !iack_req && !cpu_ready, "R1 strobes",
            {28'd0, isa_rd, isa_wr, iack_req, cpu_ready}, 32'd0);
      check(cpu_rdata == 32'd0, "R1 rdata", cpu_rdata, 32'd0);
   endtask

   task automatic t_flat();
      xfer(1, 32'h8000_03F8, 2'd0, 0, 0, 0, 0, 32'h0000_00A5, 0, 1, 16'h03F8, 0, 0,
           32'h0000_00A5, 0, "R3 flat byte read");
      xfer(0, 32'h807F_1234, 2'd0, 32'h0000_0077, 0, 0, 2, 0, 0, 1, 16'h1234,
           32'h0000_0077, 0, 0, 0, "R3 flat high bits dropped");
   endtask

   task automatic t_sparse();
      xfer(1, 32'h8012_3FF5, 2'd0, 0, 0, 1, 0, 32'h0000_0042, 0, 1, 16'h2475, 0, 0,
           32'h0000_0042, 0, "R4 sparse mid bits ignored");
      xfer(0, 32'h807F_F01F, 2'd0, 32'h0000_0011, 0, 1, 1, 0, 0, 1, 16'hFFFF,
           32'h0000_0011, 0, 0, 0, "R4 sparse top port");
   endtask

   task automatic t_write_swap();
      xfer(0, 32'h8000_0100, 2'd1, 32'h1122_3344, 1, 0, 0, 0, 0, 1, 16'h0100,
           32'h1122_4433, 0, 0, 0, "R6 BE half write");
      xfer(0, 32'h8000_0104, 2'd2, 32'h1122_3344, 1, 0, 0, 0, 0, 1, 16'h0104,
           32'h4433_2211, 0, 0, 0, "R6 BE word write");
      xfer(0, 32'h8000_0108, 2'd0, 32'h1122_3344, 1, 0, 0, 0, 0, 1, 16'h0108,
           32'h1122_3344, 0, 0, 0, "R6 BE byte write");
      xfer(0, 32'h8000_010C, 2'd2, 32'h1122_3344, 0, 0, 0, 0, 0, 1, 16'h010C,
           32'h1122_3344, 0, 0, 0, "R6 LE word write");
   endtask

   task automatic t_read_swap();
      xfer(1, 32'h8000_0200, 2'd1, 0, 1, 0, 0, 32'hAABB_CCDD, 0, 1, 16'h0200, 0, 0,
           32'hAABB_DDCC, 0, "R7 BE half read");
      xfer(1, 32'h8000_0204, 2'd2, 0, 1, 0, 3, 32'hAABB_CCDD, 0, 1, 16'h0204, 0, 0,
           32'hDDCC_BBAA, 0, "R7 BE word read");
      xfer(1, 32'h8000_0208, 2'd2, 0, 0, 0, 0, 32'hAABB_CCDD, 0, 1, 16'h0208, 0, 0,
           32'hAABB_CCDD, 0, "R7 LE word read");
   endtask

   task automatic t_iack();
      xfer(1, 32'hBFFF_FFF0, 2'd0, 0, 0, 0, 2, 0, 8'h5A, 0, 0, 0, 1,
           32'h0000_005A, 0, "R8 iack byte");
      xfer(1, 32'hBFFF_FFF0, 2'd2, 0, 1, 0, 0, 0, 8'h5A, 0, 0, 0, 1,
           32'h5A00_0000, 0, "R8 iack BE word");
      xfer(1, 32'hBFFF_FFF0, 2'd1, 0, 1, 0, 0, 0, 8'h5A, 0, 0, 0, 1,
           32'h0000_5A00, 0, "R8 iack BE half");
      xfer(1, 32'hBFFF_FFF2, 2'd0, 0, 0, 0, 0, 0, 8'h5A, 0, 0, 0, 0,
           32'h0, 0, "R9 iack other offset");
      xfer(0, 32'hBFFF_FFF0, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, 8'h5A, 0, 0, 0, 0,
           32'h0, 0, "R10 iack write ignored");
      xfer(0, 32'hBFFF_FFF3, 2'd0, 32'h0000_00FF, 0, 0, 0, 0, 8'h5A, 0, 0, 0, 0,
           32'h0, 0, "R10 iack region write ignored");
   endtask

   task automatic t_outside();
      xfer(1, 32'h0000_1000, 2'd2, 0, 0, 0, 0, 32'h1234_5678, 0, 0, 0, 0, 0,
           32'h0, 0, "R11 low memory");
      xfer(1, 32'h8080_0000, 2'd0, 0, 0, 0, 0, 32'h1234_5678, 0, 0, 0, 0, 0,
           32'h0, 0, "R11 just past window");
      xfer(0, 32'h7FFF_FFFF, 2'd0, 32'h55, 0, 1, 0, 0, 0, 0, 0, 0, 0,
           32'h0, 0, "R11 just below window");
   endtask

   task automatic t_flip_on_ack();
      xfer(1, 32'h8012_3456, 2'd2, 0, 1, 0, 2, 32'h0102_0304, 0, 1, 16'h3456, 0, 0,
           32'h0403_0201, 1, "R12 controls flip at ack");
      xfer(0, 32'h8012_3001, 2'd1, 32'h0000_BEEF, 0, 1, 1, 0, 0, 1, 16'h2461,
           32'h0000_BEEF, 0, 0, 1, "R12 sparse write flip at ack");
   endtask

   initial begin : watchdog
      #(5ns * 100000);
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flat();
      t_sparse();
      t_write_swap();
      t_read_swap();
      t_iack();
      t_outside();
      t_flip_on_ack();
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule